// File: doc/BRIEF.md
# Level-Parallel Rectangle Tree Search

This block holds a complete two-dimensional spatial tree in registers and searches it for every stored rectangle that overlaps a query rectangle. Each node has four locations arranged two by two. Each location stores a bounding rectangle, a pointer to the object or subspace it describes, and a leaf flag. With the default height of three, the tree has one root, four middle nodes and sixteen bottom nodes, for a total of 21 nodes and 84 locations.

Use follows a fixed sequence. One clock of initialize empties the tree. Every location is then written through the load port, one location per clock. A search starts with a single pulse that carries the query rectangle. The block then tests one tree level per clock, and it tests every node of that level in parallel. A location hands an enable to its child node only when it hits, so branches that miss are pruned without any split-point choice. After the last level, the sixteen bottom nodes are read back one at a time through the query port. A second search on the same tree needs no new load.

Top module: `rect_tree_search`

## Requirements
- R1: A one-clock `init` pulse marks every location empty and clears all hit results, `busy` and `done`. A search run on an empty tree reports no hits on any output node.
- R2: A load writes rectangle, pointer and leaf flag into node `ld_node`, location `ld_loc` at the next clock edge and marks that location filled. Location l of node n has child node 4n+l+1, so node 0 is the root and nodes 5..20 are the bottom level. An accepted load also clears the previous search results.
- R3: The overlap test is inclusive on all four edges. A query that only touches a stored rectangle's edge or corner counts as a hit.
- R4: The root is always enabled. Any other node is enabled only when its parent location hit and that location's leaf flag is 0. A disabled node reports no hits, even where its own rectangles overlap the query.
- R5: A location with its leaf flag set never enables its child node, even when it hits.
- R6: `busy` rises at the clock edge that accepts `start`. `done` rises exactly three edges later (one per level) at the same edge where `busy` falls, and `done` is never high while `busy` is high.
- R7: A `start` pulse that arrives while `busy` is high is ignored. The search in progress keeps its query and its results.
- R8: A later search on the same loaded tree, with no reload, gives the results for its own query.
- R9: `out_sel`=o selects bottom node 5+o. One clock later, `out_hit` bit l holds that node's location-l hit and `out_ptr` bits [8l+7:8l] hold its location-l pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Empty the tree and clear results |
| ld_en | input | 1 | Write one location this clock |
| ld_node | input | 5 | Node index of the write (0..20) |
| ld_loc | input | 2 | Location within the node (bit0 = x half, bit1 = y half) |
| ld_xlo | input | 16 | Stored rectangle low x |
| ld_ylo | input | 16 | Stored rectangle low y |
| ld_xhi | input | 16 | Stored rectangle high x |
| ld_yhi | input | 16 | Stored rectangle high y |
| ld_ptr | input | 8 | Pointer stored with the rectangle |
| ld_leaf | input | 1 | Location describes an object, not a subtree |
| start | input | 1 | Begin a search with the query rectangle below |
| srch_xlo | input | 16 | Query low x |
| srch_ylo | input | 16 | Query low y |
| srch_xhi | input | 16 | Query high x |
| srch_yhi | input | 16 | Query high y |
| busy | output | 1 | Search in progress |
| done | output | 1 | Results of the last search are ready |
| out_sel | input | 4 | Bottom-level output node to read (0..15) |
| out_hit | output | 4 | Hit vector of the selected node, one bit per location |
| out_ptr | output | 32 | Pointers of the selected node, location 0 in the low byte |

## Verification
The bench drives all inputs on the falling edge and reads outputs on the falling edge after the result is due. A load is visible at the first rising edge. `busy` is high one half-cycle after the accepting edge, `done` stays low at the next two sample points and is high at the third, and each `out_sel` value is read one full clock after it is applied. The expected hits come from a bench model that walks the tree from the root, using the enable and leaf rules, and checks are placed only at those due cycles.

// File: rtl/rect_tree_search.sv
module rect_tree_search #(
  parameter int CW = 16,
  parameter int PW = 8,
  parameter int H  = 3,
  localparam int NODES = ((1 << (2*H)) - 1) / 3,
  localparam int NLEAF = 1 << (2*(H-1)),
  localparam int NW    = $clog2(NODES),
  localparam int OW    = $clog2(NLEAF)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init,
  input  logic            ld_en,
  input  logic [NW-1:0]   ld_node,
  input  logic [1:0]      ld_loc,
  input  logic [CW-1:0]   ld_xlo,
  input  logic [CW-1:0]   ld_ylo,
  input  logic [CW-1:0]   ld_xhi,
  input  logic [CW-1:0]   ld_yhi,
  input  logic [PW-1:0]   ld_ptr,
  input  logic            ld_leaf,
  input  logic            start,
  input  logic [CW-1:0]   srch_xlo,
  input  logic [CW-1:0]   srch_ylo,
  input  logic [CW-1:0]   srch_xhi,
  input  logic [CW-1:0]   srch_yhi,
  output logic            busy,
  output logic            done,
  input  logic [OW-1:0]   out_sel,
  output logic [3:0]      out_hit,
  output logic [4*PW-1:0] out_ptr
);
  localparam int NLOC  = 4 * NODES;
  localparam int LEAF0 = (NLEAF - 1) / 3;
  localparam int LW    = $clog2(H + 1);

  function automatic int lvl_of(input int n);
    int first = 0, cnt = 1, l = 0;
    while (n >= first + cnt) begin
      first += cnt;
      cnt   *= 4;
      l++;
    end
    return l;
  endfunction

  logic [CW-1:0] sxl [NLOC];
  logic [CW-1:0] syl [NLOC];
  logic [CW-1:0] sxh [NLOC];
  logic [CW-1:0] syh [NLOC];
  logic [PW-1:0] sp  [NLOC];
  logic [NLOC-1:0] sleaf, sval, hit, hit_nxt;
  logic [CW-1:0] kxl, kyl, kxh, kyh;
  logic [LW-1:0] lvl;

  wire [NW+1:0] ld_k  = {ld_node, ld_loc};
  wire          ld_ok = ld_en && !busy && !init && (ld_node < NW'(NODES));
  wire [NW-1:0] qn    = NW'(LEAF0) + NW'(out_sel);

  always_ff @(posedge clk) begin
    if (ld_ok) begin
      sxl[ld_k]   <= ld_xlo;
      syl[ld_k]   <= ld_ylo;
      sxh[ld_k]   <= ld_xhi;
      syh[ld_k]   <= ld_yhi;
      sp[ld_k]    <= ld_ptr;
      sleaf[ld_k] <= ld_leaf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sval <= '0;
    else if (init)  sval <= '0;
    else if (ld_ok) sval[ld_k] <= 1'b1;
  end

  for (genvar n = 0; n < NODES; n++) begin : g_node
    localparam int LV = lvl_of(n);
    logic en;
    if (n == 0) begin : g_root
      assign en = 1'b1;
    end else begin : g_kid
      assign en = hit[n-1] & ~sleaf[n-1];
    end
    for (genvar l = 0; l < 4; l++) begin : g_loc
      localparam int K = 4*n + l;
      wire ov = sval[K] && (sxl[K] <= kxh) && (kxl <= sxh[K])
                        && (syl[K] <= kyh) && (kyl <= syh[K]);
      assign hit_nxt[K] = (lvl == LW'(LV)) ? (en & ov) : hit[K];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      lvl  <= '0;
      hit  <= '0;
      kxl  <= '0;
      kyl  <= '0;
      kxh  <= '0;
      kyh  <= '0;
    end else if (init) begin
      busy <= 1'b0;
      done <= 1'b0;
      lvl  <= '0;
      hit  <= '0;
    end else if (busy) begin
      hit <= hit_nxt;
      if (lvl == LW'(H-1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        lvl <= lvl + 1'b1;
      end
    end else if (start) begin
      busy <= 1'b1;
      done <= 1'b0;
      lvl  <= '0;
      hit  <= '0;
      kxl  <= srch_xlo;
      kyl  <= srch_ylo;
      kxh  <= srch_xhi;
      kyh  <= srch_yhi;
    end else if (ld_ok) begin
      hit <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_hit <= '0;
      out_ptr <= '0;
    end else begin
      out_hit <= hit[{qn, 2'b00} +: 4];
      for (int i = 0; i < 4; i++)
        out_ptr[i*PW +: PW] <= sp[{qn, 2'b00} + i];
    end
  end
endmodule

// File: rtl/rect_tree_search_chk.sv
module rect_tree_search_chk #(
  parameter int CW = 16,
  parameter int H  = 3,
  localparam int NODES = ((1 << (2*H)) - 1) / 3,
  localparam int NLEAF = 1 << (2*(H-1)),
  localparam int NLOC  = 4 * NODES,
  localparam int LEAF0 = (NLEAF - 1) / 3,
  localparam int OW    = $clog2(NLEAF)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            init,
  input logic            busy,
  input logic            done,
  input logic [NLOC-1:0] hit,
  input logic [NLOC-1:0] sleaf,
  input logic [OW-1:0]   out_sel,
  input logic [3:0]      out_hit,
  input logic [CW-1:0]   kxl,
  input logic [CW-1:0]   kyl,
  input logic [CW-1:0]   kxh,
  input logic [CW-1:0]   kyh
);
  wire [3:0] sel_hit = hit[4*(LEAF0 + int'(out_sel)) +: 4];

  p_init_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (hit == '0) && !busy && !done);

  p_busy_nodone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !init) |=> $stable(kxl) && $stable(kyl) && $stable(kxh) && $stable(kyh));

  p_query_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> out_hit == $past(sel_hit));

  for (genvar n = 1; n < NODES; n++) begin : g_gate
    p_child_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[4*n +: 4] != 4'b0) |-> (hit[n-1] && !sleaf[n-1]));
  end
endmodule

bind rect_tree_search rect_tree_search_chk #(.CW(CW), .H(H)) u_chk (
  .clk(clk), .rst_n(rst_n), .init(init), .busy(busy), .done(done),
  .hit(hit), .sleaf(sleaf), .out_sel(out_sel), .out_hit(out_hit),
  .kxl(kxl), .kyl(kyl), .kxh(kxh), .kyh(kyh)
);

// File: tb/sim_rect_tree_search.sv
module sim_rect_tree_search;
  logic clk = 1'b0, rst_n = 1'b0, init = 1'b0;
  logic ld_en = 1'b0, ld_leaf = 1'b0, start = 1'b0;
  logic [4:0] ld_node = '0;
  logic [1:0] ld_loc = '0;
  logic [15:0] ld_xlo = '0, ld_ylo = '0, ld_xhi = '0, ld_yhi = '0;
  logic [7:0] ld_ptr = '0;
  logic [15:0] srch_xlo = '0, srch_ylo = '0, srch_xhi = '0, srch_yhi = '0;
  logic [3:0] out_sel = '0;
  logic busy, done;
  logic [3:0] out_hit;
  logic [31:0] out_ptr;

  int checks = 0, errors = 0;

  int mxl[84], myl[84], mxh[84], myh[84], mptr[84];
  bit mleaf[84], mval[84], mhit[84];
  int rx[21], ry[21], rs[21];

  always #2 clk = ~clk;

  rect_tree_search u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input int k, input int xl, input int yl, input int xh,
                      input int yh, input int p, input bit lf);
    @(negedge clk);
    ld_en = 1'b1; ld_node = 5'(k / 4); ld_loc = 2'(k % 4);
    ld_xlo = 16'(xl); ld_ylo = 16'(yl); ld_xhi = 16'(xh); ld_yhi = 16'(yh);
    ld_ptr = 8'(p); ld_leaf = lf;
    mxl[k] = xl; myl[k] = yl; mxh[k] = xh; myh[k] = yh;
    mptr[k] = p; mleaf[k] = lf; mval[k] = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic do_init();
    @(negedge clk);
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    for (int k = 0; k < 84; k++) mval[k] = 1'b0;
    chk(!busy && !done, "R1 init clears busy/done", {busy, done}, 0);
  endtask

  task automatic model(input int xl, input int yl, input int xh, input int yh);
    for (int n = 0; n < 21; n++) begin
      bit en = (n == 0) ? 1'b1 : (mhit[n-1] && !mleaf[n-1]);
      for (int l = 0; l < 4; l++) begin
        int k = 4*n + l;
        mhit[k] = en && mval[k] && mxl[k] <= xh && xl <= mxh[k]
                     && myl[k] <= yh && yl <= myh[k];
      end
    end
  endtask

  task automatic search(input int xl, input int yl, input int xh, input int yh,
                        input bit dbl);
    @(negedge clk);
    start = 1'b1;
    srch_xlo = 16'(xl); srch_ylo = 16'(yl); srch_xhi = 16'(xh); srch_yhi = 16'(yh);
    @(negedge clk);
    start = dbl;
    srch_xlo = 16'd255; srch_ylo = 16'd255; srch_xhi = 16'd255; srch_yhi = 16'd255;
    chk(busy && !done, "R6 busy after accepting edge", {busy, done}, 2);
    @(negedge clk);
    start = 1'b0;
    chk(!done, "R6 done low at +2", done, 0);
    @(negedge clk);
    chk(!done && busy, "R6 done low at +3 sample", {busy, done}, 2);
    @(negedge clk);
    chk(done && !busy, "R6 done high after three levels", {busy, done}, 1);
    model(xl, yl, xh, yh);
  endtask

  task automatic check_all(input string req);
    for (int o = 0; o < 16; o++) begin
      int exp = 0;
      @(negedge clk);
      out_sel = 4'(o);
      @(negedge clk);
      for (int l = 0; l < 4; l++) exp |= int'(mhit[4*(5+o)+l]) << l;
      chk(int'(out_hit) == exp, req, out_hit, exp);
    end
  endtask

  task automatic load_tree();
    rx[0] = 0; ry[0] = 0; rs[0] = 256;
    for (int n = 0; n < 21; n++)
      for (int l = 0; l < 4; l++) begin
        int sub = rs[n] / 2;
        int x = rx[n] + (l % 2) * sub;
        int y = ry[n] + (l / 2) * sub;
        int k = 4*n + l;
        if (n < 5) begin
          rx[k+1] = x; ry[k+1] = y; rs[k+1] = sub;
          load(k, x, y, x+sub-1, y+sub-1, k, 1'b0);
        end else begin
          load(k, x+2, y+2, x+sub-3, y+sub-3, k, 1'b1);
        end
      end
  endtask

  task automatic t_reset();
    chk(!busy && !done, "R6 reset state", {busy, done}, 0);
  endtask

  task automatic t_empty();
    do_init();
    search(0, 0, 255, 255, 1'b0);
    check_all("R1 empty tree no hits");
  endtask

  task automatic t_pointers();
    load_tree();
    @(negedge clk);
    out_sel = 4'd0;
    @(negedge clk);
    chk(out_ptr == {8'd23, 8'd22, 8'd21, 8'd20}, "R2 R9 pointers node5", out_ptr, 32'h17161514);
    @(negedge clk);
    out_sel = 4'd15;
    @(negedge clk);
    chk(out_ptr == {8'd83, 8'd82, 8'd81, 8'd80}, "R2 R9 pointers node20", out_ptr, 32'h53525150);
  endtask

  task automatic t_point();
    search(100, 40, 100, 40, 1'b0);
    check_all("R4 R9 single point");
    @(negedge clk);
    out_sel = 4'd1;
    @(negedge clk);
    chk(out_hit == 4'b1000, "R9 point lands in node6 loc3", out_hit, 8);
  endtask

  task automatic t_full();
    search(0, 0, 255, 255, 1'b0);
    check_all("R8 whole space repeat search");
  endtask

  task automatic t_touch();
    search(29, 29, 29, 29, 1'b0);
    @(negedge clk);
    out_sel = 4'd0;
    @(negedge clk);
    chk(out_hit == 4'b0001, "R3 corner touch counts", out_hit, 1);
    search(0, 0, 1, 1, 1'b0);
    @(negedge clk);
    out_sel = 4'd0;
    @(negedge clk);
    chk(out_hit == 4'b0000, "R3 just outside misses", out_hit, 0);
  endtask

  task automatic t_leaf_stop();
    load(0, 0, 0, 127, 127, 0, 1'b1);
    search(5, 5, 5, 5, 1'b0);
    check_all("R5 leaf flag blocks child");
    load(0, 0, 0, 127, 127, 0, 1'b0);
    search(5, 5, 5, 5, 1'b0);
    @(negedge clk);
    out_sel = 4'd0;
    @(negedge clk);
    chk(out_hit == 4'b0001, "R5 restored path hits", out_hit, 1);
  endtask

  task automatic t_gate();
    load(21, 200, 200, 210, 210, 99, 1'b1);
    search(205, 205, 205, 205, 1'b0);
    @(negedge clk);
    out_sel = 4'd0;
    @(negedge clk);
    chk(out_hit == 4'b0000, "R4 disabled node reports nothing", out_hit, 0);
    check_all("R4 gated search");
    load(21, 34, 2, 61, 29, 21, 1'b1);
  endtask

  task automatic t_busy_start();
    search(100, 40, 100, 40, 1'b1);
    check_all("R7 start while busy ignored");
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 84; k++) begin
      mval[k] = 1'b0; mleaf[k] = 1'b0; mhit[k] = 1'b0;
      mxl[k] = 0; myl[k] = 0; mxh[k] = 0; myh[k] = 0; mptr[k] = 0;
    end
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_empty();
    t_pointers();
    t_point();
    t_full();
    t_touch();
    t_leaf_stop();
    t_gate();
    t_busy_start();
    do_init();
    search(0, 0, 255, 255, 1'b0);
    check_all("R1 init after load empties tree");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule